// File: doc/BRIEF.md
# Smart-Card T=0 Character Receiver

This block receives asynchronous characters from a smart card over the single shared, half-duplex I/O line. A bit-rate tick arrives `OVS` times per bit period. The block waits for a falling level, then confirms the start bit at its midpoint. It samples eight data bits, least significant first, and then an even parity bit, each at the middle of its bit. It then holds off new starts for a guard interval.

On a parity error, the receiver reports the problem back to the card. It pulls the line low for one bit time, starting where the parity bit ends, and then waits the full guard interval. A character with an error therefore occupies one bit time more than a clean character. Parity errors also set a status flag and advance a saturating counter, which clears when it is read. An inhibit setting suppresses the pull-down. In that mode the bad character is still stored, but the ready flag is left alone and a separate inhibit flag is raised. Two command strobes clear the two error flags.

Top module: `sc_t0_rx`

## Requirements
- R1: After reset, `rx_ready_o`, `par_err_o`, `nack_inh_o` and `io_pd_o` are 0, and `err_cnt_o` and `rx_data_o` are 0.
- R2: The frame is one start bit (0), then data bits D0..D7 with D0 first, then one parity bit that makes the ones count of data plus parity even. When the parity checks, the data goes to `rx_data_o` and `rx_ready_o` is set, both at the tick that samples the parity bit.
- R3: A start is detected on the first tick that sees the line low while the receiver is idle. The start is kept only if the line is still low `OVS/2` ticks later. Otherwise the receiver returns to idle and nothing is stored.
- R4: On a parity error with `cfg_inack_i`=0, `io_pd_o` rises `OVS/2` ticks after the parity sample and stays high for exactly `OVS` ticks.
- R5: A character with a parity error and `cfg_inack_i`=0 leaves `rx_data_o` and `rx_ready_o` unchanged and sets `par_err_o`.
- R6: `err_cnt_o` (8 bits) rises by one for each parity error in either mode. It saturates at 255 and does not wrap.
- R7: An `err_rd_i` pulse clears `err_cnt_o` to 0. A parity error in the same cycle leaves the count at 1.
- R8: On a parity error with `cfg_inack_i`=1, `io_pd_o` stays 0. The character is stored in `rx_data_o`, `rx_ready_o` is not raised, `nack_inh_o` is set and `par_err_o` is not set.
- R9: A `cmd_rst_nack_i` pulse clears `nack_inh_o`, and a `cmd_rst_sts_i` pulse clears `par_err_o`. A set in the same cycle wins.
- R10: An `rx_rd_i` pulse clears `rx_ready_o`. A new good character in the same cycle wins.
- R11: After the parity bit, the line is ignored until the guard ends. For a clean character the guard is `(GUARD_BITS*OVS + OVS/2)` ticks after the parity sample. After a NACK it is `OVS` ticks longer. A low level inside the guard starts no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | Enable pulse, `OVS` per bit period |
| io_i | input | 1 | Sampled level of the shared I/O line |
| io_pd_o | output | 1 | Pull-down enable for the open-drain line driver |
| cfg_inack_i | input | 1 | 1: suppress the NACK, keep the bad character |
| cmd_rst_nack_i | input | 1 | Pulse: clear `nack_inh_o` |
| cmd_rst_sts_i | input | 1 | Pulse: clear `par_err_o` |
| rx_rd_i | input | 1 | Pulse: clear `rx_ready_o` |
| rx_data_o | output | 8 | Last stored character |
| rx_ready_o | output | 1 | A good character is waiting |
| par_err_o | output | 1 | A parity error was answered with a NACK |
| nack_inh_o | output | 1 | A parity error was seen while the NACK was inhibited |
| err_rd_i | input | 1 | Pulse: read and clear the error count |
| err_cnt_o | output | 8 | Saturating parity error count |

## Verification
Counted from the tick that sees the start edge, the data, ready and flag results settle on tick 76. With OVS=8, the pull-down covers ticks 81 to 88 after a NACK, and the receiver is idle again by tick 97 for a clean character or tick 105 after a NACK. The bench drives the line in step with the ticks it generates. It checks the pull-down at ticks 81, 87 and 88, which brackets both of its edges, and reads the data and flags only after tick 105, when every register on the path has settled. Strobe results are due one clock after the strobe and are sampled on the following falling clock edge.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_TAIL,
    ST_NACK,
    ST_GUARD
  } rx_state_e;
endpackage

// File: rtl/sc_t0_shift.sv
module sc_t0_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [DW-1:0] data_o,
  output logic          par_o
);
  logic [DW-1:0] sr_q;
  logic          par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      par_q <= 1'b0;
    end else if (clr_i) begin
      par_q <= 1'b0;
    end else if (shift_i) begin
      sr_q  <= {bit_i, sr_q[DW-1:1]};  // LSB first
      par_q <= par_q ^ bit_i;
    end
  end

  assign data_o = sr_q;
  assign par_o  = par_q;
endmodule

// File: rtl/sc_t0_err_cnt.sv
module sc_t0_err_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, base;

  always_comb begin
    base = clr_i ? '0 : cnt_q;
    if (inc_i && base != MAX) base = base + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= base;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sc_t0_rx.sv
module sc_t0_rx
  import sc_t0_pkg::*;
#(
  parameter int OVS        = 8,
  parameter int GUARD_BITS = 2,
  parameter int DW         = 8,
  parameter int CW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_tick_i,
  input  logic          io_i,
  output logic          io_pd_o,
  input  logic          cfg_inack_i,
  input  logic          cmd_rst_nack_i,
  input  logic          cmd_rst_sts_i,
  input  logic          rx_rd_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_ready_o,
  output logic          par_err_o,
  output logic          nack_inh_o,
  input  logic          err_rd_i,
  output logic [CW-1:0] err_cnt_o
);
  localparam int HALF   = OVS / 2;
  localparam int GTICKS = GUARD_BITS * OVS;
  localparam int TW     = $clog2(GTICKS + 1);
  localparam int IW     = $clog2(DW + 1);

  rx_state_e     state_q;
  logic [TW-1:0] tcnt_q;
  logic [IW-1:0] idx_q;
  logic          nack_q;
  logic [DW-1:0] data_q;
  logic          ready_q, perr_q, inh_q;

  logic          samp, shift_en, last, confirm, par_acc, bad;
  logic [DW-1:0] sh_data;

  // mid-bit sample point inside the data/parity phase
  assign samp     = bit_tick_i && state_q == ST_DATA && tcnt_q == TW'(OVS - 1);
  assign shift_en = samp && idx_q < IW'(DW);
  assign last     = samp && idx_q == IW'(DW);
  assign confirm  = bit_tick_i && state_q == ST_START && tcnt_q == TW'(HALF - 1) && !io_i;
  assign bad      = last && (par_acc ^ io_i);

  sc_t0_shift #(.DW(DW)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (confirm),
    .shift_i(shift_en),
    .bit_i  (io_i),
    .data_o (sh_data),
    .par_o  (par_acc)
  );

  sc_t0_err_cnt #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (bad),
    .clr_i (err_rd_i),
    .cnt_o (err_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      nack_q  <= 1'b0;
    end else if (bit_tick_i) begin
      case (state_q)
        ST_IDLE: if (!io_i) begin
          state_q <= ST_START;
          tcnt_q  <= '0;
        end
        ST_START: begin
          if (tcnt_q == TW'(HALF - 1)) begin
            state_q <= io_i ? ST_IDLE : ST_DATA;
            tcnt_q  <= '0;
            idx_q   <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        ST_DATA: begin
          if (tcnt_q == TW'(OVS - 1)) begin
            tcnt_q <= '0;
            idx_q  <= idx_q + 1'b1;
            if (idx_q == IW'(DW)) begin
              state_q <= ST_TAIL;
              nack_q  <= bad && !cfg_inack_i;
            end
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        ST_TAIL: begin
          if (tcnt_q == TW'(HALF - 1)) begin
            state_q <= nack_q ? ST_NACK : ST_GUARD;
            tcnt_q  <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        ST_NACK: begin
          if (tcnt_q == TW'(OVS - 1)) begin
            state_q <= ST_GUARD;
            tcnt_q  <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        ST_GUARD: begin
          if (tcnt_q == TW'(GTICKS - 1)) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // result registers; a set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      inh_q   <= 1'b0;
    end else begin
      if (last && (!bad || cfg_inack_i)) data_q <= sh_data;

      if (last && !bad)  ready_q <= 1'b1;
      else if (rx_rd_i)  ready_q <= 1'b0;

      if (bad && !cfg_inack_i) perr_q <= 1'b1;
      else if (cmd_rst_sts_i)  perr_q <= 1'b0;

      if (bad && cfg_inack_i)  inh_q <= 1'b1;
      else if (cmd_rst_nack_i) inh_q <= 1'b0;
    end
  end

  assign io_pd_o    = state_q == ST_NACK;
  assign rx_data_o  = data_q;
  assign rx_ready_o = ready_q;
  assign par_err_o  = perr_q;
  assign nack_inh_o = inh_q;
endmodule

// File: rtl/sc_t0_rx_chk.sv
module sc_t0_rx_chk #(
  parameter int OVS = 8,
  parameter int DW  = 8,
  parameter int CW  = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_tick_i,
  input logic          cfg_inack_i,
  input logic          rx_rd_i,
  input logic          err_rd_i,
  input logic          io_pd_o,
  input logic          rx_ready_o,
  input logic          par_err_o,
  input logic [DW-1:0] rx_data_o,
  input logic [CW-1:0] err_cnt_o
);
  localparam int PW = $clog2(OVS + 2);

  logic [PW-1:0] pd_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pd_ticks <= '0;
    else if (!io_pd_o)          pd_ticks <= '0;
    else if (bit_tick_i)        pd_ticks <= pd_ticks + 1'b1;
  end

  AST_PD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(io_pd_o) |-> pd_ticks == PW'(OVS));  // R4
  AST_INACK_NO_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_pd_o) |-> !$past(cfg_inack_i));  // R8
  AST_BAD_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(par_err_o) |-> $stable(rx_data_o));  // R5
  AST_CNT_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(err_rd_i) |-> err_cnt_o >= $past(err_cnt_o));  // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CW+1)'(err_cnt_o) <= (CW+1)'($past(err_cnt_o)) + 1'b1);  // R6
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_rd_i) |-> err_cnt_o <= CW'(1));  // R7
  AST_READY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_ready_o) |-> $past(rx_rd_i));  // R10
endmodule

bind sc_t0_rx sc_t0_rx_chk #(.OVS(OVS), .DW(DW), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_tick_i (bit_tick_i),
  .cfg_inack_i(cfg_inack_i),
  .rx_rd_i    (rx_rd_i),
  .err_rd_i   (err_rd_i),
  .io_pd_o    (io_pd_o),
  .rx_ready_o (rx_ready_o),
  .par_err_o  (par_err_o),
  .rx_data_o  (rx_data_o),
  .err_cnt_o  (err_cnt_o)
);

// File: tb/sc_t0_rx_bench.sv
module sc_t0_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tx_q = 1'b1;
  logic       io_line, io_pd;
  logic       inack = 1'b0, rst_nack = 1'b0, rst_sts = 1'b0, rx_rd = 1'b0, err_rd = 1'b0;
  logic [7:0] rx_data, err_cnt;
  logic       rx_ready, par_err, nack_inh;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n) tick <= ~tick;

  assign io_line = tx_q & ~io_pd;  // wired-AND line

  sc_t0_rx u_sc_t0_rx (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .io_i(io_line), .io_pd_o(io_pd),
    .cfg_inack_i(inack), .cmd_rst_nack_i(rst_nack), .cmd_rst_sts_i(rst_sts),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_ready_o(rx_ready), .par_err_o(par_err),
    .nack_inh_o(nack_inh), .err_rd_i(err_rd), .err_cnt_o(err_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  // tick 0 = first tick seeing start; parity sampled on tick 76
  task automatic frame(input logic [7:0] d, input bit good, input bit exp_nack, input bit do_chk);
    logic [9:0] bits;
    bits = {good ? ^d : ~^d, d};
    tx_q = 1'b0;
    wait_ticks(OVS);
    for (int b = 0; b < 9; b++) begin
      tx_q = bits[b];
      wait_ticks(OVS);
    end
    tx_q = 1'b1;
    wait_ticks(2);                                         // after tick 81
    if (do_chk) chk(exp_nack ? "R4 pd on" : "R8/R4 pd off", io_pd, exp_nack);
    wait_ticks(6);                                         // after tick 87
    if (do_chk && exp_nack) chk("R4 pd held", io_pd, 1);
    wait_ticks(1);                                         // after tick 88
    if (do_chk) chk("R4 pd released", io_pd, 0);
    wait_ticks(17);                                        // after tick 105, idle
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_d;
    repeat (3) @(negedge clk);
    chk("R1 ready", rx_ready, 0);
    chk("R1 pd", io_pd, 0);
    chk("R1 cnt", err_cnt, 0);
    chk("R1 perr", par_err, 0);
    chk("R1 inh", nack_inh, 0);
    chk("R1 data", rx_data, 0);
    rst_n = 1'b1;
    wait_ticks(4);

    // R2 sweep of all data values with good parity; R10 read clear
    for (int v = 0; v < 256; v++) begin
      frame(8'(v), 1'b1, 1'b0, v < 4);
      chk("R2 data", rx_data, v);
      chk("R2 ready", rx_ready, 1);
      chk("R2 no perr", par_err, 0);
      pulse(rx_rd);
      chk("R10 ready clr", rx_ready, 0);
    end
    chk("R6 no errors", err_cnt, 0);
    last_d = 8'hFF;

    // R5/R4 parity error answered by NACK
    frame(8'hA5, 1'b0, 1'b1, 1'b1);
    chk("R5 data kept", rx_data, last_d);
    chk("R5 ready", rx_ready, 0);
    chk("R5 perr", par_err, 1);
    chk("R6 cnt 1", err_cnt, 1);
    pulse(err_rd);
    chk("R7 cnt clr", err_cnt, 0);
    pulse(rst_sts);
    chk("R9 perr clr", par_err, 0);

    // R8 inhibit mode
    inack = 1'b1;
    frame(8'h3C, 1'b0, 1'b0, 1'b1);
    chk("R8 data stored", rx_data, 8'h3C);
    chk("R8 ready", rx_ready, 0);
    chk("R8 inh", nack_inh, 1);
    chk("R8 perr", par_err, 0);
    chk("R6 cnt inh", err_cnt, 1);
    pulse(rst_nack);
    chk("R9 inh clr", nack_inh, 0);
    pulse(err_rd);
    inack = 1'b0;

    // R3 false start: low for 2 ticks only
    tx_q = 1'b0;
    wait_ticks(2);
    tx_q = 1'b1;
    wait_ticks(100);
    chk("R3 no ready", rx_ready, 0);
    chk("R3 data", rx_data, 8'h3C);
    chk("R3 pd", io_pd, 0);
    chk("R3 perr", par_err, 0);
    frame(8'h81, 1'b1, 1'b0, 1'b1);
    chk("R3 next frame", rx_data, 8'h81);
    pulse(rx_rd);

    // R11 low inside guard must not start a character
    begin
      tx_q = 1'b0;
      wait_ticks(OVS);
      for (int b = 0; b < 9; b++) begin
        tx_q = (b < 8) ? 1'(8'h5A >> b) : ^8'h5A;
        wait_ticks(OVS);
      end
      tx_q = 1'b1;
      wait_ticks(2);
      tx_q = 1'b0;
      wait_ticks(10);
      tx_q = 1'b1;
      wait_ticks(120);
      chk("R11 data", rx_data, 8'h5A);
      chk("R11 ready", rx_ready, 1);
      chk("R11 perr", par_err, 0);
      chk("R11 cnt", err_cnt, 0);
      pulse(rx_rd);
    end

    // R6 saturation
    for (int k = 0; k < 255; k++) frame(8'(k), 1'b0, 1'b1, 1'b0);
    chk("R6 cnt 255", err_cnt, 255);
    frame(8'h11, 1'b0, 1'b1, 1'b1);
    chk("R6 saturate", err_cnt, 255);
    pulse(err_rd);
    chk("R7 clr from sat", err_cnt, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule